// File: doc/BRIEF.md
# Shared Memory VMEbus Slave Bridge

This block lets a VMEbus master read and write a shared RAM that a local processor also uses. Software places a window in the 32-bit VME address space through a page-number input with 4 KB granularity. When a qualified strobe cycle falls inside that window, the block first checks the address-modifier code against a write-protect rule. It then asks the local arbiter for the bus and runs a single local memory cycle once the bus is granted. Finally it answers the VME master with DTACK or BERR.

The local side of every transfer is short. A read stops as soon as the memory word has been captured in a holding register, and a write stops as soon as the memory acknowledges it. The local bus request is dropped on that same edge. The VME side then finishes on its own asynchronous handshake: DTACK and the held read data stay valid until the master releases its data strobe. The local processor sees the same RAM at address zero, so the address sent to memory is the offset of the VME address from the start of the window.

Top module: `vme_shram_slave`

## Requirements
- R1: An access is claimed only if the address-modifier code is 0x09, 0x0A, 0x0D or 0x0E (bits 5..3 equal 001, bits 1..0 equal 01 or 10) and the page number (address bits 31..12) minus `vme_page_base` is below the number of 4 KB pages in the RAM (16 by default). Any other access gets no request, no DTACK and no BERR.
- R2: The local address equals the VME address minus (`vme_page_base` times 4096), truncated to the RAM width. The base may be any 4 KB multiple, and the local RAM starts at 0.
- R3: Address-modifier bit 2 marks supervisor mode. Supervisor accesses may read and write. User accesses (bit 2 = 0) may only read.
- R4: A user-mode write inside the window drives `vme_berr_n` low, never raises `loc_req` or `loc_cyc`, and leaves memory unchanged. BERR is held until the data strobe is released.
- R5: A claimed, permitted access raises `loc_req`. `loc_cyc` rises only on the edge after `loc_gnt` was sampled high while requesting.
- R6: On a read, the block captures `loc_rdata` on the edge where `loc_ack` is high. `vme_rdata` then holds that word, unchanged, for the whole time `vme_dtack_n` is low.
- R7: On a write, `loc_we` is high during the local cycle and `loc_wdata` carries the VME write data. The cycle ends on the edge where `loc_ack` is high.
- R8: `loc_req` and `loc_cyc` fall on the same edge that drives `vme_dtack_n` low. DTACK stays low until the synchronised data strobe reads high.
- R9: Address and data strobes pass through two flip-flops. With both strobes driven low just after a falling clock edge, the first response (`loc_req` or `vme_berr_n`) appears after the third rising edge.
- R10: After DTACK or BERR, a data strobe that stays low does not start a second transfer. A new access is taken only after the strobe has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vme_as_n | input | 1 | VME address strobe, active low, asynchronous |
| vme_ds_n | input | 1 | VME data strobe, active low, asynchronous |
| vme_write_n | input | 1 | VME write line, low = write |
| vme_am | input | 6 | Address-modifier code |
| vme_addr | input | ADDR_W | VME byte address |
| vme_wdata | input | DATA_W | VME write data |
| vme_page_base | input | ADDR_W-12 | Window base as a 4 KB page number |
| vme_rdata | output | DATA_W | Held read data |
| vme_dtack_n | output | 1 | Data acknowledge, active low |
| vme_berr_n | output | 1 | Bus error, active low |
| loc_req | output | 1 | Local bus request |
| loc_gnt | input | 1 | Local bus grant |
| loc_cyc | output | 1 | Local memory cycle active |
| loc_we | output | 1 | Local write enable |
| loc_addr | output | RAM_AW | Local RAM byte address |
| loc_wdata | output | DATA_W | Local write data |
| loc_rdata | input | DATA_W | Local read data |
| loc_ack | input | 1 | Local memory acknowledge |

## Verification
Two events can land on one edge: the local bus is handed back, and DTACK is asserted toward the master. Both happen on the edge where the memory acknowledges. The bench provokes the tightest case by parking the grant high and acknowledging in the first cycle of the local cycle, so that request, cycle and answer follow each other with no idle cycle. A reference model, stepped every clock, predicts request, cycle, DTACK and BERR, and each is compared cycle by cycle. A second overlap, a data strobe still held low after the answer, is held for several cycles to show that release and re-acceptance never merge.

// File: rtl/shram_pkg.sv
package shram_pkg;

  localparam int PAGE_SHIFT = 12;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_CYC  = 3'd2,
    ST_ACK  = 3'd3,
    ST_ERR  = 3'd4
  } slv_state_t;

  // single-word A32 data or program access, either privilege
  function automatic logic am_single_a32(input logic [5:0] am);
    return (am[5:3] == 3'b001) && (am[1:0] == 2'b01 || am[1:0] == 2'b10);
  endfunction

  function automatic logic am_super(input logic [5:0] am);
    return am[2];
  endfunction

endpackage

// File: rtl/shram_sync2.sv
module shram_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= async_i[g];
        sync_q <= meta_q;
      end
    end
    assign sync_o[g] = sync_q;
  end

endmodule

// File: rtl/shram_win_decode.sv
module shram_win_decode
  import shram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RAM_AW = 16
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [5:0]                   am_i,
  input  logic                         write_n_i,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] base_i,
  output logic                         hit_o,
  output logic                         deny_o,
  output logic                         is_write_o,
  output logic                         is_super_o,
  output logic [RAM_AW-1:0]            offset_o
);

  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int RAM_PW = RAM_AW - PAGE_SHIFT;

  logic [PAGE_W-1:0] page_diff;
  logic              in_window;

  always_comb begin
    page_diff  = addr_i[ADDR_W-1:PAGE_SHIFT] - base_i;
    in_window  = (page_diff >> RAM_PW) == '0;
    is_write_o = !write_n_i;
    is_super_o = am_super(am_i);
    hit_o      = in_window && am_single_a32(am_i);
    deny_o     = hit_o && is_write_o && !is_super_o;
    offset_o   = {page_diff[RAM_PW-1:0], addr_i[PAGE_SHIFT-1:0]};
  end

endmodule

// File: rtl/shram_slave_fsm.sv
module shram_slave_fsm
  import shram_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RAM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_s,
  input  logic              ds_s,
  input  logic              hit_i,
  input  logic              deny_i,
  input  logic              is_write_i,
  input  logic              is_super_i,
  input  logic [RAM_AW-1:0] offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lgnt_i,
  input  logic              lack_i,
  input  logic [DATA_W-1:0] lrdata_i,
  output logic              lreq_o,
  output logic              lcyc_o,
  output logic              lwe_o,
  output logic [RAM_AW-1:0] laddr_o,
  output logic [DATA_W-1:0] lwdata_o,
  output logic              dtack_n_o,
  output logic              berr_n_o,
  output logic [DATA_W-1:0] rdata_o
);

  slv_state_t        state_q, state_d;
  logic              we_q, sup_q;
  logic [RAM_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              start, take_acc, take_rd;

  always_comb begin
    start    = (state_q == ST_IDLE) && !as_s && !ds_s && hit_i;
    take_acc = start && !deny_i;
    take_rd  = (state_q == ST_CYC) && lack_i && !we_q;
    state_d  = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = deny_i ? ST_ERR : ST_REQ;
      ST_REQ:  if (lgnt_i) state_d = ST_CYC;
      ST_CYC:  if (lack_i) state_d = ST_ACK;
      ST_ACK:  if (ds_s) state_d = ST_IDLE;
      ST_ERR:  if (ds_s) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      sup_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take_acc) begin
      we_q    <= is_write_i;
      sup_q   <= is_super_i;
      addr_q  <= offset_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (take_rd) rdata_q <= lrdata_i;
  end

  always_comb begin
    lreq_o    = (state_q == ST_REQ) || (state_q == ST_CYC);
    lcyc_o    = (state_q == ST_CYC);
    lwe_o     = lcyc_o && we_q;
    laddr_o   = addr_q;
    lwdata_o  = wdata_q;
    dtack_n_o = (state_q != ST_ACK);
    berr_n_o  = (state_q != ST_ERR);
    rdata_o   = rdata_q;
  end

  // R5: local cycle only after grant
  a_r5_cyc_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcyc_o) |-> $past(lgnt_i)) else $error("R5 cycle without grant");

  // R8: bus handed back on the edge DTACK goes low
  a_r8_release_with_dtack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n_o) |-> ($fell(lreq_o) && $past(lack_i))) else $error("R8 release mismatch");

  // R10: answer is withdrawn only after strobe seen released
  a_r10_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dtack_n_o) || $rose(berr_n_o)) |-> $past(ds_s)) else $error("R10 early release");

  // R4: a denied access never touches the local bus
  a_r4_no_bus_on_berr: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_n_o |-> (!lreq_o && !lcyc_o)) else $error("R4 bus used on error");

  // R6: read data steady while acknowledged
  a_r6_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n_o && $past(!dtack_n_o)) |-> $stable(rdata_o)) else $error("R6 data moved");

  // R3: only supervisor accesses write memory
  a_r3_write_is_super: assert property (@(posedge clk) disable iff (!rst_n)
    lwe_o |-> sup_q) else $error("R3 user write reached memory");

  // R4: never both answers
  a_r4_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!dtack_n_o, !berr_n_o, lcyc_o})) else $error("R4 overlapping answers");

endmodule

// File: rtl/vme_shram_slave.sv
module vme_shram_slave
  import shram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RAM_AW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vme_as_n,
  input  logic                         vme_ds_n,
  input  logic                         vme_write_n,
  input  logic [5:0]                   vme_am,
  input  logic [ADDR_W-1:0]            vme_addr,
  input  logic [DATA_W-1:0]            vme_wdata,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] vme_page_base,
  output logic [DATA_W-1:0]            vme_rdata,
  output logic                         vme_dtack_n,
  output logic                         vme_berr_n,
  output logic                         loc_req,
  input  logic                         loc_gnt,
  output logic                         loc_cyc,
  output logic                         loc_we,
  output logic [RAM_AW-1:0]            loc_addr,
  output logic [DATA_W-1:0]            loc_wdata,
  input  logic [DATA_W-1:0]            loc_rdata,
  input  logic                         loc_ack
);

  // reset: asserted at once, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [1:0] strb_s;
  shram_sync2 #(.WIDTH(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i ({vme_as_n, vme_ds_n}),
    .sync_o  (strb_s)
  );

  logic              hit, deny, is_write, is_super;
  logic [RAM_AW-1:0] offset;

  shram_win_decode #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_dec (
    .addr_i     (vme_addr),
    .am_i       (vme_am),
    .write_n_i  (vme_write_n),
    .base_i     (vme_page_base),
    .hit_o      (hit),
    .deny_o     (deny),
    .is_write_o (is_write),
    .is_super_o (is_super),
    .offset_o   (offset)
  );

  shram_slave_fsm #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .as_s       (strb_s[1]),
    .ds_s       (strb_s[0]),
    .hit_i      (hit),
    .deny_i     (deny),
    .is_write_i (is_write),
    .is_super_i (is_super),
    .offset_i   (offset),
    .wdata_i    (vme_wdata),
    .lgnt_i     (loc_gnt),
    .lack_i     (loc_ack),
    .lrdata_i   (loc_rdata),
    .lreq_o     (loc_req),
    .lcyc_o     (loc_cyc),
    .lwe_o      (loc_we),
    .laddr_o    (loc_addr),
    .lwdata_o   (loc_wdata),
    .dtack_n_o  (vme_dtack_n),
    .berr_n_o   (vme_berr_n),
    .rdata_o    (vme_rdata)
  );

endmodule

// File: tb/vme_shram_slave_test.sv
`timescale 1ns/1ps
module vme_shram_slave_test;

  localparam int RAM_AW = 16;
  localparam int PAGES  = 1 << (RAM_AW - 12);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vme_as_n = 1'b1, vme_ds_n = 1'b1, vme_write_n = 1'b1;
  logic [5:0]  vme_am = '0;
  logic [31:0] vme_addr = '0, vme_wdata = '0;
  logic [19:0] vme_page_base = 20'h40100;
  logic [31:0] vme_rdata;
  logic        vme_dtack_n, vme_berr_n;
  logic        loc_req, loc_gnt = 1'b0, loc_cyc, loc_we, loc_ack = 1'b0;
  logic [RAM_AW-1:0] loc_addr;
  logic [31:0] loc_wdata, loc_rdata = '0;

  always #2.5 clk = ~clk;

  vme_shram_slave #(.ADDR_W(32), .DATA_W(32), .RAM_AW(RAM_AW)) uut (.*);

  int compared = 0, mismatched = 0;
  int gdly = 1, adly = 1;
  bit park = 1'b0;
  int g_cnt = 0, c_cnt = 0, cycles = 0;
  logic [31:0] mem [int];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit b_hit(input logic [31:0] a, input logic [5:0] am, input logic [19:0] base);
    logic [19:0] d;
    d = a[31:12] - base;
    return (am[5:3] == 3'b001) && (am[1:0] == 2'b01 || am[1:0] == 2'b10) && (d < PAGES);
  endfunction

  function automatic logic [RAM_AW-1:0] b_off(input logic [31:0] a, input logic [19:0] base);
    logic [19:0] d;
    d = a[31:12] - base;
    return {d[RAM_AW-13:0], a[11:0]};
  endfunction

  function automatic logic [31:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // reference model: 0 idle, 1 requesting, 2 local cycle, 3 acknowledged, 4 error
  int m_ph = 0;
  bit m_as1 = 1, m_as2 = 1, m_ds1 = 1, m_ds2 = 1, m_we = 0;
  logic [RAM_AW-1:0] m_off = '0;
  logic [31:0] m_wd = '0, m_rd = '0;

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ph = 0; m_as1 = 1; m_as2 = 1; m_ds1 = 1; m_ds2 = 1; m_rd = '0;
    end else begin
      case (m_ph)
        0: if (!m_as2 && !m_ds2 && b_hit(vme_addr, vme_am, vme_page_base)) begin
             if (!vme_write_n && !vme_am[2]) m_ph = 4;
             else begin
               m_ph = 1; m_we = !vme_write_n;
               m_off = b_off(vme_addr, vme_page_base); m_wd = vme_wdata;
             end
           end
        1: if (loc_gnt) m_ph = 2;
        2: if (loc_ack) begin m_ph = 3; if (!m_we) m_rd = loc_rdata; end
        default: if (m_ds2) m_ph = 0;
      endcase
      m_as2 = m_as1; m_as1 = vme_as_n;
      m_ds2 = m_ds1; m_ds1 = vme_ds_n;
    end
    chk("R5 loc_req", loc_req, (m_ph == 1 || m_ph == 2));
    chk("R5 loc_cyc", loc_cyc, (m_ph == 2));
    chk("R8 dtack_n", vme_dtack_n, !(m_ph == 3));
    chk("R4 berr_n", vme_berr_n, !(m_ph == 4));
    if (m_ph == 2) begin
      chk("R2 loc_addr", loc_addr, m_off);
      chk("R7 loc_we", loc_we, m_we);
      if (m_we) chk("R7 loc_wdata", loc_wdata, m_wd);
    end
    if (m_ph == 3 && !m_we) chk("R6 vme_rdata", vme_rdata, m_rd);
    // arbiter and RAM stand-ins
    g_cnt = loc_req ? g_cnt + 1 : 0;
    loc_gnt = park ? 1'b1 : (loc_req && g_cnt > gdly);
    c_cnt = loc_cyc ? c_cnt + 1 : 0;
    loc_ack = loc_cyc && (c_cnt > adly);
    loc_rdata = loc_cyc ? mem_rd(int'(loc_addr)) : 32'hBAD0_BAD0;
    if (loc_ack && loc_we) mem[int'(loc_addr)] = loc_wdata;
  end

  // kind: 0 acknowledged, 1 bus error, 2 ignored
  task automatic xfer(input string tag, input logic [31:0] a, input logic [5:0] am, input bit wr,
                      input logic [31:0] wd, input int kind, input int hold, output logic [31:0] rd);
    int n;
    @(negedge clk); #1;
    vme_addr = a; vme_am = am; vme_write_n = !wr; vme_wdata = wd;
    vme_as_n = 1'b0; vme_ds_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!loc_req && vme_berr_n && n < 12);
    if (kind == 2) begin
      chk({tag, " R1 ignored"}, {loc_req, vme_berr_n, vme_dtack_n}, 3'b011);
    end else begin
      chk({tag, " R9 latency"}, n, 3);
      chk({tag, " R3/R4 answer kind"}, !vme_berr_n, kind == 1);
      n = 0;
      while (vme_dtack_n && vme_berr_n && n < 100) begin @(negedge clk); n++; end
      rd = vme_rdata;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk({tag, " R10 no second request"}, loc_req, 1'b0);
      end
    end
    @(negedge clk); #1;
    vme_as_n = 1'b1; vme_ds_n = 1'b1;
    n = 0;
    while ((!vme_dtack_n || !vme_berr_n) && n < 10) begin @(negedge clk); n++; end
    chk({tag, " R8 answer released"}, {vme_dtack_n, vme_berr_n}, 2'b11);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 100000) begin
        mismatched++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk("R8 reset dtack_n", vme_dtack_n, 1'b1);
    chk("R4 reset berr_n", vme_berr_n, 1'b1);
    chk("R5 reset loc_req", loc_req, 1'b0);
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R3 supervisor write then read back (R6, R7)
    xfer("sup wr", 32'h4010_0010, 6'h0D, 1, 32'hCAFE_0001, 0, 0, rd);
    chk("R7 memory written", mem_rd(16'h0010), 32'hCAFE_0001);
    xfer("sup rd", 32'h4010_0010, 6'h0D, 0, '0, 0, 0, rd);
    chk("R6 read back", rd, 32'hCAFE_0001);
    // R3 user read allowed, program space
    xfer("usr rd", 32'h4010_0010, 6'h09, 0, '0, 0, 0, rd);
    chk("R3 user read", rd, 32'hCAFE_0001);
    xfer("prg rd", 32'h4010_0010, 6'h0E, 0, '0, 0, 0, rd);
    chk("R1 program read", rd, 32'hCAFE_0001);
    // R4 user write denied, memory untouched
    xfer("usr wr", 32'h4010_0010, 6'h09, 1, 32'h1111_2222, 1, 0, rd);
    xfer("after deny", 32'h4010_0010, 6'h0D, 0, '0, 0, 0, rd);
    chk("R4 memory unchanged", rd, 32'hCAFE_0001);
    // R1 boundaries and wrong codes
    xfer("top", 32'h4010_FFFC, 6'h0D, 1, 32'h7777_0000, 0, 0, rd);
    chk("R1 top word stored", mem_rd(16'hFFFC), 32'h7777_0000);
    xfer("past top", 32'h4011_0000, 6'h0D, 1, 32'h1, 2, 0, rd);
    xfer("below", 32'h400F_FFFC, 6'h0D, 1, 32'h2, 2, 0, rd);
    xfer("a24 code", 32'h4010_0010, 6'h3D, 0, '0, 2, 0, rd);
    xfer("block code", 32'h4010_0010, 6'h0F, 0, '0, 2, 0, rd);
    // R2 unaligned base moves the window, local address still from zero
    vme_page_base = 20'h40103;
    xfer("moved base", 32'h4010_3010, 6'h0D, 0, '0, 0, 0, rd);
    chk("R2 offset read", rd, 32'hCAFE_0001);
    xfer("old addr", 32'h4010_0010, 6'h0D, 0, '0, 2, 0, rd);
    // R10 strobe held low after answer
    xfer("hold", 32'h4010_3020, 6'h0D, 1, 32'hABCD_0002, 0, 8, rd);
    chk("R10 single write", mem_rd(16'h0020), 32'hABCD_0002);
    xfer("hold err", 32'h4010_3020, 6'h0A, 1, 32'h3, 1, 6, rd);
    // parked grant, immediate ack: release and DTACK on one edge (R8)
    park = 1'b1; gdly = 0; adly = 0;
    xfer("fast wr", 32'h4010_3030, 6'h0E, 1, 32'h5A5A_A5A5, 0, 0, rd);
    xfer("fast rd", 32'h4010_3030, 6'h0D, 0, '0, 0, 0, rd);
    chk("R8 fast read", rd, 32'h5A5A_A5A5);
    park = 1'b0; gdly = 5; adly = 4;
    xfer("slow rd", 32'h4010_3020, 6'h09, 0, '0, 0, 0, rd);
    chk("R5 slow grant read", rd, 32'hABCD_0002);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule